// File: doc/BRIEF.md
# Vector Compare Predicate Generator

This block runs a branch-type comparison across the elements of two register-file operands. Its result is a predicate bitmask, not a jump. When a command starts, each operand is classed as scalar or vector from its configured length. A vector operand walks consecutive registers from its base. A scalar operand supplies its base register to every element. The block compares one element pair per cycle. It sets mask bit i when the comparison for element i is true, then writes the whole mask to a destination integer register in a single write.

When neither operand is a vector, the same command reduces to an ordinary branch. One comparison is made, and the block reports taken or not taken with no register write. Register data arrives through a read port with two addresses and one cycle of read latency, which is the behaviour of a synchronous block RAM.

Top module: `vcmp_pred_gen`

## Requirements
- R1: After reset, `busy`, `done`, `wr_en` and `br_valid` are all low.
- R2: An operand is a vector when its length input is greater than one and a scalar otherwise. When both operands are scalar, exactly one compare is made, `br_valid` pulses with `br_taken` carrying the result, and `wr_en` stays low.
- R3: For element i, a vector operand reads register (base + i) modulo the number of registers, and a scalar operand reads its base register.
- R4: In vector mode, bit i of `wr_mask` is 1 exactly when the compare for element i is true, for every i below the element count. The mask is written once, with `wr_en` high and `wr_addr` equal to the destination captured at start.
- R5: `cmp_op` selects the compare: 3'b000 equal, 3'b001 not equal, 3'b100 signed less-than, 3'b101 signed greater-or-equal, 3'b110 unsigned less-than, 3'b111 unsigned greater-or-equal. The codes 3'b010 and 3'b011 never compare true.
- R6: In vector mode the element count is `vec_len` clamped to the mask width. Mask bits at or above that count are zero. With `vec_len` of 0, a mask of all zeros is written.
- R7: Elements are compared at one per cycle. `done`, together with `wr_en` or `br_valid`, is high in the cycle that follows the (N+1)-th clock edge after the edge that accepts `start`. N is the element count, which is 1 for a branch, and `done` is not high earlier.
- R8: `done` is a one-cycle pulse. `busy` rises at the edge that accepts `start` and falls at the edge that raises `done`.
- R9: A `start` that arrives while `busy` is high is ignored, and the running command's results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a command when idle |
| cmp_op | input | 3 | Compare selector |
| src1_base | input | REG_AW | First operand base register |
| src2_base | input | REG_AW | Second operand base register |
| src1_len | input | LEN_W | First operand configured length |
| src2_len | input | LEN_W | Second operand configured length |
| vec_len | input | LEN_W | Active vector length |
| dest_reg | input | REG_AW | Register that receives the mask |
| rd_addr1 | output | REG_AW | Read address, first operand |
| rd_addr2 | output | REG_AW | Read address, second operand |
| rd_data1 | input | DATA_W | Read data for `rd_addr1`, one cycle later |
| rd_data2 | input | DATA_W | Read data for `rd_addr2`, one cycle later |
| wr_en | output | 1 | Mask write strobe |
| wr_addr | output | REG_AW | Mask write register |
| wr_mask | output | DATA_W | Predicate mask |
| br_valid | output | 1 | Scalar branch decision strobe |
| br_taken | output | 1 | Scalar branch result |
| done | output | 1 | Command finished pulse |
| busy | output | 1 | Command in progress |

## Verification
Let N be the element count: 1 for a branch, or the clamped vector length, which may be 0. The results then appear in the cycle after the (N+1)-th rising edge that follows the edge accepting `start`. That is one edge to issue each element address, one for the register-file read, and one to register the compare and the outcome. The bench computes N from the inputs it drove and steps that many falling edges. At each falling edge before the last it confirms that `done` is low, at the last it checks the mask or branch outputs, and at the following falling edge it confirms that `done` has dropped. Because every sample falls half a period away from the rising edges, no check depends on the order of events at a clock edge.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  typedef enum logic [2:0] {
    CMP_EQ  = 3'b000,
    CMP_NE  = 3'b001,
    CMP_RS0 = 3'b010,
    CMP_RS1 = 3'b011,
    CMP_LT  = 3'b100,
    CMP_GE  = 3'b101,
    CMP_LTU = 3'b110,
    CMP_GEU = 3'b111
  } cmp_kind_e;
endpackage

// File: rtl/vcp_issue.sv
module vcp_issue #(
  parameter int REG_AW = 5,
  parameter int MASK_W = 32,
  parameter int LEN_W  = 6,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        cmp_op,
  input  logic [REG_AW-1:0] src1_base,
  input  logic [REG_AW-1:0] src2_base,
  input  logic [LEN_W-1:0]  src1_len,
  input  logic [LEN_W-1:0]  src2_len,
  input  logic [LEN_W-1:0]  vec_len,
  input  logic [REG_AW-1:0] dest_reg,
  input  logic              fin_now,
  output logic              busy,
  output logic              iss_vld,
  output logic [IDX_W-1:0]  iss_idx,
  output logic              iss_last,
  output logic              zero_req,
  output logic [REG_AW-1:0] addr1,
  output logic [REG_AW-1:0] addr2,
  output logic [2:0]        op_q,
  output logic [REG_AW-1:0] dest_q,
  output logic              vec_q
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MASK_W);

  logic              run_q;
  logic              s1_q, s2_q;
  logic [REG_AW-1:0] b1_q, b2_q;
  logic [LEN_W-1:0]  cnt_q, n_q;
  logic              s1_in, s2_in, vec_in;
  logic [LEN_W-1:0]  n_in;

  always_comb begin
    s1_in  = src1_len > LEN_ONE;
    s2_in  = src2_len > LEN_ONE;
    vec_in = s1_in | s2_in;
    if (!vec_in)                n_in = LEN_ONE;
    else if (vec_len > LEN_MAX) n_in = LEN_MAX;
    else                        n_in = vec_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      run_q    <= 1'b0;
      iss_vld  <= 1'b0;
      iss_idx  <= '0;
      iss_last <= 1'b0;
      zero_req <= 1'b0;
      addr1    <= '0;
      addr2    <= '0;
      op_q     <= '0;
      dest_q   <= '0;
      vec_q    <= 1'b0;
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      b1_q     <= '0;
      b2_q     <= '0;
      cnt_q    <= '0;
      n_q      <= '0;
    end else begin
      iss_vld  <= 1'b0;
      zero_req <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        op_q   <= cmp_op;
        dest_q <= dest_reg;
        vec_q  <= vec_in;
        s1_q   <= s1_in;
        s2_q   <= s2_in;
        b1_q   <= src1_base;
        b2_q   <= src2_base;
        n_q    <= n_in;
        addr1  <= src1_base;
        addr2  <= src2_base;
        cnt_q  <= LEN_ONE;
        run_q  <= n_in > LEN_ONE;
        if (n_in == '0) begin
          zero_req <= 1'b1;
        end else begin
          iss_vld  <= 1'b1;
          iss_idx  <= '0;
          iss_last <= n_in == LEN_ONE;
        end
      end else if (busy) begin
        if (fin_now) busy <= 1'b0;
        if (run_q) begin
          iss_vld  <= 1'b1;
          iss_idx  <= cnt_q[IDX_W-1:0];
          iss_last <= cnt_q == n_q - LEN_ONE;
          addr1    <= b1_q + (s1_q ? REG_AW'(cnt_q) : '0);
          addr2    <= b2_q + (s2_q ? REG_AW'(cnt_q) : '0);
          cnt_q    <= cnt_q + LEN_ONE;
          run_q    <= cnt_q != n_q - LEN_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/vcp_cmp.sv
module vcp_cmp
  import vcp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              hit
);
  always_comb begin
    case (cmp_kind_e'(op))
      CMP_EQ:  hit = a == b;
      CMP_NE:  hit = a != b;
      CMP_LT:  hit = $signed(a) <  $signed(b);
      CMP_GE:  hit = $signed(a) >= $signed(b);
      CMP_LTU: hit = a <  b;
      CMP_GEU: hit = a >= b;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcp_acc.sv
module vcp_acc #(
  parameter int MASK_W = 32,
  parameter int REG_AW = 5,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_vld,
  input  logic [IDX_W-1:0]  iss_idx,
  input  logic              iss_last,
  input  logic              zero_req,
  input  logic              hit,
  input  logic              vec_q,
  input  logic [REG_AW-1:0] dest_q,
  output logic              fin_now,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [MASK_W-1:0] wr_mask,
  output logic              br_valid,
  output logic              br_taken,
  output logic              done
);
  logic              dat_vld, dat_last;
  logic [IDX_W-1:0]  dat_idx;
  logic [MASK_W-1:0] mask_q, mask_nx;
  logic              first;

  assign first   = dat_vld && (dat_idx == '0);
  assign fin_now = (dat_vld && dat_last) || zero_req;

  for (genvar g = 0; g < MASK_W; g++) begin : g_bit
    always_comb begin
      if (dat_vld && dat_idx == IDX_W'(g)) mask_nx[g] = hit;
      else if (first)                      mask_nx[g] = 1'b0;
      else                                 mask_nx[g] = mask_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_vld  <= 1'b0;
      dat_last <= 1'b0;
      dat_idx  <= '0;
      mask_q   <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_mask  <= '0;
      br_valid <= 1'b0;
      br_taken <= 1'b0;
      done     <= 1'b0;
    end else begin
      dat_vld  <= iss_vld;
      dat_last <= iss_last;
      dat_idx  <= iss_idx;
      mask_q   <= mask_nx;
      done     <= fin_now;
      wr_en    <= fin_now && vec_q;
      br_valid <= fin_now && !vec_q;
      if (fin_now) begin
        if (vec_q) begin
          wr_addr <= dest_q;
          wr_mask <= zero_req ? '0 : mask_nx;
        end else begin
          br_taken <= hit;
        end
      end
    end
  end
endmodule

// File: rtl/vcmp_pred_gen.sv
module vcmp_pred_gen #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  localparam int MASK_W = DATA_W,
  localparam int LEN_W  = $clog2(MASK_W + 1),
  localparam int IDX_W  = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        cmp_op,
  input  logic [REG_AW-1:0] src1_base,
  input  logic [REG_AW-1:0] src2_base,
  input  logic [LEN_W-1:0]  src1_len,
  input  logic [LEN_W-1:0]  src2_len,
  input  logic [LEN_W-1:0]  vec_len,
  input  logic [REG_AW-1:0] dest_reg,
  output logic [REG_AW-1:0] rd_addr1,
  output logic [REG_AW-1:0] rd_addr2,
  input  logic [DATA_W-1:0] rd_data1,
  input  logic [DATA_W-1:0] rd_data2,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_mask,
  output logic              br_valid,
  output logic              br_taken,
  output logic              done,
  output logic              busy
);
  logic              fin_now, iss_vld, iss_last, zero_req, vec_q, hit;
  logic [IDX_W-1:0]  iss_idx;
  logic [2:0]        op_q;
  logic [REG_AW-1:0] dest_q;

  vcp_issue #(.REG_AW(REG_AW), .MASK_W(MASK_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_issue (
    .clk(clk), .rst(rst), .start(start), .cmp_op(cmp_op),
    .src1_base(src1_base), .src2_base(src2_base),
    .src1_len(src1_len), .src2_len(src2_len), .vec_len(vec_len),
    .dest_reg(dest_reg), .fin_now(fin_now), .busy(busy),
    .iss_vld(iss_vld), .iss_idx(iss_idx), .iss_last(iss_last),
    .zero_req(zero_req), .addr1(rd_addr1), .addr2(rd_addr2),
    .op_q(op_q), .dest_q(dest_q), .vec_q(vec_q)
  );

  vcp_cmp #(.DATA_W(DATA_W)) u_cmp (
    .op(op_q), .a(rd_data1), .b(rd_data2), .hit(hit)
  );

  vcp_acc #(.MASK_W(MASK_W), .REG_AW(REG_AW), .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_idx(iss_idx),
    .iss_last(iss_last), .zero_req(zero_req), .hit(hit),
    .vec_q(vec_q), .dest_q(dest_q), .fin_now(fin_now),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
    .br_valid(br_valid), .br_taken(br_taken), .done(done)
  );
endmodule

// File: rtl/vcmp_pred_gen_chk.sv
module vcmp_pred_gen_chk #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [LEN_W-1:0]  vec_len,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_mask,
  input logic              br_valid,
  input logic              done,
  input logic              busy
);
  logic [LEN_W-1:0]  cap_n;
  logic [DATA_W-1:0] low_bits;

  always_ff @(posedge clk) begin
    if (rst) cap_n <= '0;
    else if (start && !busy)
      cap_n <= (vec_len > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : vec_len;
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) low_bits[i] = LEN_W'(i) < cap_n;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_fall_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_busy_rise_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_write_is_done_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (done && !busy));
  assert_branch_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    br_valid |-> (done && !wr_en));
  assert_done_has_result_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (wr_en || br_valid));
  assert_high_bits_zero_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wr_mask & ~low_bits) == '0));
endmodule

bind vcmp_pred_gen vcmp_pred_gen_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .vec_len(vec_len), .wr_en(wr_en),
  .wr_mask(wr_mask), .br_valid(br_valid), .done(done), .busy(busy)
);

// File: tb/test_vcmp_pred_gen.sv
`timescale 1ns/1ps
module test_vcmp_pred_gen;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int LW = 4;
  localparam int NR = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    cmp_op = '0;
  logic [AW-1:0] src1_base = '0, src2_base = '0, dest_reg = '0;
  logic [LW-1:0] src1_len = '0, src2_len = '0, vec_len = '0;
  logic [AW-1:0] rd_addr1, rd_addr2, wr_addr;
  logic [DW-1:0] rd_data1, rd_data2, wr_mask;
  logic          wr_en, br_valid, br_taken, done, busy;
  logic [DW-1:0] regs [NR];

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    rd_data1 <= regs[rd_addr1];
    rd_data2 <= regs[rd_addr2];
  end

  vcmp_pred_gen #(.DATA_W(DW), .REG_AW(AW)) i_vcmp_pred_gen (
    .clk(clk), .rst(rst), .start(start), .cmp_op(cmp_op),
    .src1_base(src1_base), .src2_base(src2_base),
    .src1_len(src1_len), .src2_len(src2_len), .vec_len(vec_len),
    .dest_reg(dest_reg), .rd_addr1(rd_addr1), .rd_addr2(rd_addr2),
    .rd_data1(rd_data1), .rd_data2(rd_data2), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_mask(wr_mask), .br_valid(br_valid),
    .br_taken(br_taken), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_cmp(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      0: return a == b;
      1: return a != b;
      4: return $signed(a) <  $signed(b);
      5: return $signed(a) >= $signed(b);
      6: return a <  b;
      7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_op(input int op, input int b1, input int b2, input int l1,
                        input int l2, input int vl, input int dst);
    bit s1 = l1 > 1;
    bit s2 = l2 > 1;
    bit vec = s1 || s2;
    int n = vec ? ((vl > DW) ? DW : vl) : 1;
    logic [DW-1:0] exp_mask = '0;
    bit exp_tk;
    bit early = 0;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] a = regs[(b1 + (s1 ? i : 0)) % NR];
      logic [DW-1:0] b = regs[(b2 + (s2 ? i : 0)) % NR];
      exp_mask[i] = ref_cmp(op, a, b);
    end
    exp_tk = ref_cmp(op, regs[b1], regs[b2]);
    @(negedge clk);
    cmp_op = op[2:0]; src1_base = b1[AW-1:0]; src2_base = b2[AW-1:0];
    src1_len = l1[LW-1:0]; src2_len = l2[LW-1:0]; vec_len = vl[LW-1:0];
    dest_reg = dst[AW-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", busy, 1);
    for (int k = 1; k <= n + 1; k++) begin
      if (k == 1 && n >= 2) begin
        // R9: second start while busy, with different fields
        cmp_op = op[2:0] ^ 3'b001; dest_reg = dst[AW-1:0] ^ 4'h1;
        vec_len = 4'd1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (k < n + 1 && done) early = 1;
    end
    start = 1'b0;
    check(!early && done, "R7 done timing", done, 1);
    check(!busy, "R8 busy low with done", busy, 0);
    if (vec) begin
      check(wr_en && !br_valid, "R2 vector mode writes mask", wr_en, 1);
      check(wr_mask == exp_mask, "R4 R5 R3 R6 R9 mask value", wr_mask, exp_mask);
      check(wr_addr == dst[AW-1:0], "R4 R9 write address", wr_addr, dst);
    end else begin
      check(br_valid && !wr_en, "R2 scalar branch strobe", br_valid, 1);
      check(br_taken == exp_tk, "R2 R5 branch taken", br_taken, exp_tk);
    end
    @(negedge clk);
    check(!done && !wr_en && !br_valid, "R8 done pulse ends", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    regs[0]  = 8'h00; regs[1]  = 8'h7F; regs[2]  = 8'h80; regs[3]  = 8'hFF;
    regs[4]  = 8'h01; regs[5]  = 8'h80; regs[6]  = 8'h7F; regs[7]  = 8'h00;
    regs[8]  = 8'h10; regs[9]  = 8'hF0; regs[10] = 8'h10; regs[11] = 8'h05;
    regs[12] = 8'hFE; regs[13] = 8'h02; regs[14] = 8'h80; regs[15] = 8'h7F;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !wr_en && !br_valid, "R1 reset state", busy, 0);
    for (int op = 0; op < 8; op++)
      for (int m = 0; m < 4; m++)
        for (int bp = 0; bp < 2; bp++)
          for (int vl = 0; vl < 10; vl++) begin
            int l1 = m[1] ? 3 : (m == 0 ? 0 : 1);
            int l2 = m[0] ? 6 : 1;
            int b1 = bp ? 12 : 2;
            int b2 = bp ? 12 : 9;
            run_op(op, b1, b2, l1, l2, vl, (op * 4 + m + bp + vl) % NR);
          end
    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule